// File: doc/BRIEF.md
# SPI Buffer and Error Status Unit

This unit sits between a register bus and the shift-register engine of an SPI port. It holds one transmit word and one receive word, and tracks whether each holds data. It hands the shifter a word whenever a load is requested, and takes the received word when a transfer completes.

Three fault conditions are watched: a load request that finds the transmit word empty (underrun), a completed transfer that finds the receive word still unread (overrun), and a bus write to the transmit word in the same cycle as a shifter load (collision). Each fault sets a sticky flag that software clears by writing a one to its bit. Two control inputs choose what happens to the data on underrun and on overrun. The role (slave) and clock phase are inputs, and they are used to suppress collision reporting in the one mode where the collision cannot be observed reliably.

Top module: `spi_bufstat`

## Requirements
- R1: After reset every status bit is 0, both buffers are empty, and both the receive word and the transmit load word read as zero.
- R2: A bus write stores the word and sets transmit-full (status bit 3) in the next cycle. A shifter load with no write in the same cycle clears transmit-full. When both happen in one cycle the written word is kept and transmit-full stays 1.
- R3: A shifter load request while transmit-full is 0 sets the underrun flag (status bit 0) in the next cycle.
- R4: The load word equals the transmit buffer when it is full. On underrun it is all zeros when send-zero is 1, and the previous buffer contents when send-zero is 0.
- R5: A completed transfer sets receive-full (status bit 4) in the next cycle. A bus read with no completion in the same cycle clears it. The receive word output always shows the buffer.
- R6: A completed transfer while receive-full is 1 and no bus read happens in the same cycle sets the overrun flag (status bit 1).
- R7: On overrun, get-more 1 replaces the buffer with the new word; get-more 0 keeps the old word and drops the new one. With no overrun the new word is always stored.
- R8: A bus write in the same cycle as a shifter load sets the collision flag (status bit 2).
- R9: While slave is 1 and clock phase is 0 a collision never sets the collision flag.
- R10: Writing a one to clear bit n (0 underrun, 1 overrun, 2 collision) clears flag n in the next cycle; a zero leaves it. A flag stays set until cleared, and a new event in the same cycle as its clear leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_send_zero_i | input | 1 | 1: underrun shifts zeros; 0: repeats old transmit word |
| cfg_get_more_i | input | 1 | 1: overrun overwrites receive word; 0: keeps old word |
| cfg_slave_i | input | 1 | Port is in slave role |
| cfg_cpha_i | input | 1 | Clock phase setting |
| bus_tx_wr_i | input | 1 | Bus write strobe for the transmit word |
| bus_tx_data_i | input | DATA_W | Bus write data |
| bus_rx_rd_i | input | 1 | Bus read strobe for the receive word |
| bus_rx_data_o | output | DATA_W | Receive buffer contents |
| sts_clr_i | input | 3 | Write-one-to-clear mask for the three error flags |
| sts_o | output | 5 | {rx_full, tx_full, collision, overrun, underrun} |
| sh_load_req_i | input | 1 | Shifter requests a word; all start conditions met |
| sh_load_data_o | output | DATA_W | Word handed to the shifter |
| sh_done_i | input | 1 | Shifter finished a transfer |
| sh_rx_data_i | input | DATA_W | Word received by the shifter |

## Verification
The bench sweeps every combination of the four control inputs and, for each, drives a long pseudo-random mix of writes, loads, completions, reads and clears, so that same-cycle coincidences come up many times: write with load, read with completion, clear with event. A design that let the load win over a coinciding write would lose the written word and report the buffer empty; one that treated a coinciding read as an overrun would set a false flag and drop data. Directed steps pin down the slave, phase-0 suppression, where a missing gate shows a collision flag, and the clear-versus-event race, where a wrong priority drops a fresh error.

// File: rtl/spi_bufstat_pkg.sv
package spi_bufstat_pkg;
  // Error flag positions; the low bits of the status word and the clear mask.
  localparam int unsigned ERR_UNDERRUN = 0;
  localparam int unsigned ERR_OVERRUN  = 1;
  localparam int unsigned ERR_COLLIDE  = 2;
  localparam int unsigned NUM_ERR      = 3;
  // Read-only occupancy bits above the error flags.
  localparam int unsigned STS_TX_FULL  = NUM_ERR;
  localparam int unsigned STS_RX_FULL  = NUM_ERR + 1;
  localparam int unsigned STS_W        = NUM_ERR + 2;

  typedef logic [NUM_ERR-1:0] err_vec_t;
endpackage

// File: rtl/spi_tx_buf.sv
module spi_tx_buf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ld_req_i,
  input  logic              send_zero_i,
  output logic [DATA_W-1:0] ld_data_o,
  output logic              full_o,
  output logic              underrun_evt_o,
  output logic              collide_raw_o
);
  logic              full_q, full_d;
  logic [DATA_W-1:0] buf_q;

  // A coinciding write wins: the new word stays pending.
  always_comb begin
    full_d = full_q;
    if (wr_en_i)       full_d = 1'b1;
    else if (ld_req_i) full_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      buf_q  <= '0;
    end else begin
      full_q <= full_d;
      if (wr_en_i) buf_q <= wr_data_i;
    end
  end

  assign ld_data_o      = (!full_q && send_zero_i) ? '0 : buf_q;
  assign full_o         = full_q;
  assign underrun_evt_o = ld_req_i & ~full_q;
  assign collide_raw_o  = ld_req_i & wr_en_i;

  // R2
  wr_sets_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> full_q);
  // R2
  load_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_req_i && !wr_en_i |=> !full_q);
  // R2
  write_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> buf_q == $past(wr_data_i));
  // R4
  zero_on_underrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_req_i && underrun_evt_o && send_zero_i |-> ld_data_o == '0);
endmodule

// File: rtl/spi_rx_buf.sv
module spi_rx_buf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_en_i,
  input  logic [DATA_W-1:0] cap_data_i,
  input  logic              rd_en_i,
  input  logic              get_more_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              full_o,
  output logic              overrun_evt_o
);
  logic              full_q, full_d;
  logic [DATA_W-1:0] buf_q;
  logic              keep_old;
  logic              buf_we;

  // The old word survives only if it is unread and the policy says keep.
  assign keep_old = full_q & ~rd_en_i & ~get_more_i;
  assign buf_we   = cap_en_i & ~keep_old;

  always_comb begin
    full_d = full_q;
    if (cap_en_i)     full_d = 1'b1;
    else if (rd_en_i) full_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      buf_q  <= '0;
    end else begin
      full_q <= full_d;
      if (buf_we) buf_q <= cap_data_i;
    end
  end

  assign rd_data_o     = buf_q;
  assign full_o        = full_q;
  assign overrun_evt_o = cap_en_i & full_q & ~rd_en_i;

  // R5
  cap_sets_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_en_i |=> full_q);
  // R5
  read_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !cap_en_i |=> !full_q);
  // R7
  keep_old_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_en_i && full_q && !rd_en_i && !get_more_i |=> $stable(buf_q));
  // R7
  overwrite_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_en_i && get_more_i |=> buf_q == $past(cap_data_i));
endmodule

// File: rtl/spi_sticky_flags.sv
module spi_sticky_flags #(
  parameter int unsigned NUM_FLAGS = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_FLAGS-1:0] evt_i,
  input  logic [NUM_FLAGS-1:0] clr_i,
  output logic [NUM_FLAGS-1:0] flag_o
);
  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    logic flag_q, flag_d;

    // The event is ORed in after the clear, so it wins a same-cycle race.
    always_comb begin
      flag_d = (flag_q & ~clr_i[g]) | evt_i[g];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else         flag_q <= flag_d;
    end

    assign flag_o[g] = flag_q;

    // R10
    event_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[g] |=> flag_q);
    // R10
    sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_q && !clr_i[g] |=> flag_q);
    // R10
    clear_works_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[g] && !evt_i[g] |=> !flag_q);
  end
endmodule

// File: rtl/spi_bufstat.sv
module spi_bufstat
  import spi_bufstat_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_send_zero_i,
  input  logic                cfg_get_more_i,
  input  logic                cfg_slave_i,
  input  logic                cfg_cpha_i,
  input  logic                bus_tx_wr_i,
  input  logic [DATA_W-1:0]   bus_tx_data_i,
  input  logic                bus_rx_rd_i,
  output logic [DATA_W-1:0]   bus_rx_data_o,
  input  logic [NUM_ERR-1:0]  sts_clr_i,
  output logic [STS_W-1:0]    sts_o,
  input  logic                sh_load_req_i,
  output logic [DATA_W-1:0]   sh_load_data_o,
  input  logic                sh_done_i,
  input  logic [DATA_W-1:0]   sh_rx_data_i
);
  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic     tx_full, rx_full;
  logic     underrun_evt, overrun_evt, collide_raw;
  logic     collide_blind;
  err_vec_t err_evt, err_flag;

  spi_tx_buf #(.DATA_W(DATA_W)) i_tx (
    .clk_i          (clk_i),
    .rst_ni         (rst_sync_n),
    .wr_en_i        (bus_tx_wr_i),
    .wr_data_i      (bus_tx_data_i),
    .ld_req_i       (sh_load_req_i),
    .send_zero_i    (cfg_send_zero_i),
    .ld_data_o      (sh_load_data_o),
    .full_o         (tx_full),
    .underrun_evt_o (underrun_evt),
    .collide_raw_o  (collide_raw)
  );

  spi_rx_buf #(.DATA_W(DATA_W)) i_rx (
    .clk_i         (clk_i),
    .rst_ni        (rst_sync_n),
    .cap_en_i      (sh_done_i),
    .cap_data_i    (sh_rx_data_i),
    .rd_en_i       (bus_rx_rd_i),
    .get_more_i    (cfg_get_more_i),
    .rd_data_o     (bus_rx_data_o),
    .full_o        (rx_full),
    .overrun_evt_o (overrun_evt)
  );

  // Slave with phase 0 cannot see a collision in time; report none.
  assign collide_blind = cfg_slave_i & ~cfg_cpha_i;

  always_comb begin
    err_evt               = '0;
    err_evt[ERR_UNDERRUN] = underrun_evt;
    err_evt[ERR_OVERRUN]  = overrun_evt;
    err_evt[ERR_COLLIDE]  = collide_raw & ~collide_blind;
  end

  spi_sticky_flags #(.NUM_FLAGS(NUM_ERR)) i_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .evt_i  (err_evt),
    .clr_i  (sts_clr_i),
    .flag_o (err_flag)
  );

  always_comb begin
    sts_o              = '0;
    sts_o[NUM_ERR-1:0] = err_flag;
    sts_o[STS_TX_FULL] = tx_full;
    sts_o[STS_RX_FULL] = rx_full;
  end

  // R3
  underrun_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    sh_load_req_i && !sts_o[STS_TX_FULL] |=> sts_o[ERR_UNDERRUN]);
  // R6
  overrun_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    sh_done_i && sts_o[STS_RX_FULL] && !bus_rx_rd_i |=> sts_o[ERR_OVERRUN]);
  // R8
  collide_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    bus_tx_wr_i && sh_load_req_i && (!cfg_slave_i || cfg_cpha_i) |=> sts_o[ERR_COLLIDE]);
  // R9
  collide_blind_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    cfg_slave_i && !cfg_cpha_i && !sts_o[ERR_COLLIDE] |=> !sts_o[ERR_COLLIDE]);
endmodule

// File: tb/test_spi_bufstat.sv
module test_spi_bufstat;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;
  localparam int CYC_PER_CFG = 500;
  localparam int WATCHDOG   = 100000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         sz, gm, slv, cpha;
  logic         wr, rd, ld, done;
  logic [W-1:0] wdata, rdata;
  logic [2:0]   clr;
  logic [W-1:0] rx_out, ld_out;
  logic [4:0]   sts;

  int n_chk  = 0;
  int n_fail = 0;

  // Bench model state, from the requirements.
  logic [W-1:0] m_txbuf, m_rxbuf;
  logic         m_txfull, m_rxfull, m_ur, m_ov, m_col;
  logic [31:0]  lfsr = 32'h1d87_a3c5;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_bufstat #(.DATA_W(W)) i_spi_bufstat (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .cfg_send_zero_i (sz),
    .cfg_get_more_i  (gm),
    .cfg_slave_i     (slv),
    .cfg_cpha_i      (cpha),
    .bus_tx_wr_i     (wr),
    .bus_tx_data_i   (wdata),
    .bus_rx_rd_i     (rd),
    .bus_rx_data_o   (rx_out),
    .sts_clr_i       (clr),
    .sts_o           (sts),
    .sh_load_req_i   (ld),
    .sh_load_data_o  (ld_out),
    .sh_done_i       (done),
    .sh_rx_data_i    (rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr = 0; rd = 0; ld = 0; done = 0; clr = 3'b000;
    wdata = '0; rdata = '0;
  endtask

  // Inputs are set at a falling edge; this checks, clocks and checks again.
  task automatic step();
    logic [W-1:0] exp_ld, n_txbuf, n_rxbuf;
    logic         n_txfull, n_rxfull, e_ur, e_ov, e_col;
    #1;
    exp_ld = (!m_txfull && sz) ? '0 : m_txbuf;
    chk("R4 load word", ld_out, exp_ld);
    chk("R5 R7 receive word", rx_out, m_rxbuf);
    e_ur  = ld && !m_txfull;
    e_ov  = done && m_rxfull && !rd;
    e_col = wr && ld && !(slv && !cpha);
    n_txbuf  = wr ? wdata : m_txbuf;
    n_txfull = wr ? 1'b1 : (ld ? 1'b0 : m_txfull);
    n_rxbuf  = (done && (!m_rxfull || rd || gm)) ? rdata : m_rxbuf;
    n_rxfull = done ? 1'b1 : (rd ? 1'b0 : m_rxfull);
    @(posedge clk);
    #1;
    m_txbuf = n_txbuf; m_txfull = n_txfull;
    m_rxbuf = n_rxbuf; m_rxfull = n_rxfull;
    m_ur  = (m_ur  & ~clr[0]) | e_ur;
    m_ov  = (m_ov  & ~clr[1]) | e_ov;
    m_col = (m_col & ~clr[2]) | e_col;
    chk("R3 R10 underrun flag", sts[0], m_ur);
    chk("R6 R10 overrun flag", sts[1], m_ov);
    chk("R8 R9 R10 collision flag", sts[2], m_col);
    chk("R2 transmit full", sts[3], m_txfull);
    chk("R5 receive full", sts[4], m_rxfull);
    @(negedge clk);
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_txbuf = '0; m_rxbuf = '0; m_txfull = 0; m_rxfull = 0;
    m_ur = 0; m_ov = 0; m_col = 0;
  endtask

  task automatic next_rand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    sz = 0; gm = 0; slv = 0; cpha = 0;
    @(negedge clk);
    do_reset();
    #1;
    // R1
    chk("R1 status after reset", sts, 5'b00000);
    chk("R1 receive word after reset", rx_out, 0);
    chk("R1 load word after reset", ld_out, 0);
    @(negedge clk);

    // R2 / R4: write then load, then underrun repeats old word.
    wr = 1; wdata = 8'hA5; step(); idle_inputs();
    chk("R2 full after write", sts[3], 1);
    ld = 1; step(); idle_inputs();
    ld = 1; #1; chk("R4 old word repeated", ld_out, 8'hA5); step(); idle_inputs();
    chk("R3 underrun set", sts[0], 1);
    sz = 1; #1; chk("R4 zeros on empty", ld_out, 8'h00); sz = 0;

    // R9: slave, phase 0 hides a collision; phase 1 shows it.
    slv = 1; cpha = 0; wr = 1; wdata = 8'h3C; ld = 1; step(); idle_inputs();
    chk("R9 collision suppressed", sts[2], 0);
    chk("R2 written word kept on collision", sts[3], 1);
    cpha = 1; wr = 1; wdata = 8'h4B; ld = 1; step(); idle_inputs();
    chk("R8 collision flagged", sts[2], 1);

    // R10: clear racing a new event keeps the flag; clear alone drops it.
    clr = 3'b100; wr = 1; ld = 1; step(); idle_inputs();
    chk("R10 event wins over clear", sts[2], 1);
    clr = 3'b100; step(); idle_inputs();
    chk("R10 clear alone", sts[2], 0);

    // R6 / R7: overrun with keep policy.
    done = 1; rdata = 8'h11; step(); idle_inputs();
    done = 1; rdata = 8'h22; step(); idle_inputs();
    chk("R6 overrun set", sts[1], 1);
    #1; chk("R7 old word kept", rx_out, 8'h11); @(negedge clk);

    // Sweep every control combination with pseudo-random traffic.
    for (int c = 0; c < 16; c++) begin
      {sz, gm, slv, cpha} = c[3:0];
      do_reset();
      for (int k = 0; k < CYC_PER_CFG; k++) begin
        next_rand();
        wr    = lfsr[0];
        ld    = lfsr[1] & lfsr[2];
        done  = lfsr[3] & lfsr[4];
        rd    = lfsr[5];
        clr   = {lfsr[6] & lfsr[7] & lfsr[8], lfsr[9] & lfsr[10] & lfsr[11],
                 lfsr[12] & lfsr[13] & lfsr[14]};
        wdata = lfsr[22:15];
        rdata = lfsr[30:23];
        step();
      end
      idle_inputs();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule